// File: doc/BRIEF.md
# Palette Bank Switch Controller

The controller holds one 32-bit control word with four change-request flags. Each flag belongs to one colour palette, and each palette has an active bank and a shadow bank. Software sets a flag by writing 1 to it over a simple register bus. The swap itself waits for the next update event. An update event is either a falling edge of the display-reset control input or a one-cycle internal update pulse.

At an update event, every palette whose flag is set toggles its one-bit bank-select output. All flags then clear themselves, so one write requests exactly one swap. A flag bit cannot be cleared by software. When a software set and the hardware clear fall in the same cycle, the clear wins. The palette memories are outside this block and follow the bank-select outputs.

Top module: `palette_bank_switch`

## Requirements
- R1: After reset, all four flags read 0, `bank_sel` is 4'b0000 and `bus_rdata` is 0.
- R2: A read with `bus_ren` high at address `REG_ADDR` (default 0) returns the flags one cycle later. Bit 16+i holds the flag of palette i+1, for i = 0..3. In any cycle without such a read, `bus_rdata` is 0.
- R3: Bits 31..20 and 15..0 of the read word are always 0. Writing 1 to those bits changes no flag and no bank-select.
- R4: Writing 1 to a flag bit sets that flag. Writing 0 to a flag bit leaves it unchanged.
- R5: A write to any address other than `REG_ADDR` has no effect.
- R6: A 1-to-0 transition of `disp_rst` between two consecutive clock edges is an update event. A rising edge or a steady level is not an update event.
- R7: A cycle with `upd_pulse` high is an update event.
- R8: On the edge that follows an update event, `bank_sel[i]` toggles if and only if flag i was set in the event cycle. Outside update events, `bank_sel` does not change.
- R9: After an update event, all flags read 0.
- R10: If a write sets a flag in the same cycle as an update event, that flag ends at 0 and its `bank_sel` bit does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Word address |
| bus_wen | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_ren` |
| disp_rst | input | 1 | Display-reset control bit; its falling edge is an update event |
| upd_pulse | input | 1 | Internal update pulse, one cycle wide |
| bank_sel | output | NUM_PAL (4) | Bank select for each palette |

## Verification
A bad flag state shows up on `bus_rdata` one cycle after a read. If no read is made, it shows up at the next update event as a missing or extra toggle of `bank_sel`. A bad edge detector shows up as a `bank_sel` toggle one edge too early, too late, or on a rising edge of `disp_rst`. The bench compares `bank_sel` and `bus_rdata` with a behavioural model after every edge. A fault is therefore caught within one cycle of the first output it corrupts.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
    localparam int unsigned DATA_W = 32;
endpackage

// File: rtl/pbs_update_detect.sv
module pbs_update_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic disp_rst,
    input  logic upd_pulse,
    output logic evt
);
    typedef struct packed {
        logic prev;
    } det_state_t;

    det_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = disp_rst;
        evt       = (st_q.prev & ~disp_rst) | upd_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FALL_IS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(disp_rst) && !disp_rst) |-> evt); // R6
    AST_PULSE_IS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> evt); // R7
endmodule

// File: rtl/pbs_flag_bank.sv
module pbs_flag_bank #(
    parameter int unsigned NUM_PAL = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PAL-1:0] set_req,
    input  logic               evt,
    output logic [NUM_PAL-1:0] flags,
    output logic [NUM_PAL-1:0] bank_sel
);
    typedef struct packed {
        logic [NUM_PAL-1:0] flag;
        logic [NUM_PAL-1:0] bank;
    } fb_state_t;

    fb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_PAL; i++) begin
            if (evt) begin
                st_d.bank[i] = st_q.bank[i] ^ st_q.flag[i];
                st_d.flag[i] = 1'b0;
            end else begin
                st_d.flag[i] = st_q.flag[i] | set_req[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags    = st_q.flag;
    assign bank_sel = st_q.bank;

    AST_CLEAR_AFTER_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (flags == '0)); // R9
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(bank_sel)); // R8
    AST_FLAG_NO_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> ((flags & $past(flags)) == $past(flags))); // R4
    AST_SAME_CYCLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && (set_req & ~flags) != '0) |=>
        (((bank_sel ^ $past(bank_sel)) & $past(set_req & ~flags)) == '0)); // R10
endmodule

// File: rtl/pbs_bus_port.sv
module pbs_bus_port
    import pbs_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0,
    parameter int unsigned NUM_PAL  = 4,
    parameter int unsigned FLAG_LSB = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wen,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_ren,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_PAL-1:0] flags,
    output logic [NUM_PAL-1:0] set_req
);
    localparam logic [DATA_W-1:0] FLAG_MASK = {{(DATA_W-NUM_PAL){1'b0}}, {NUM_PAL{1'b1}}} << FLAG_LSB;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bp_state_t;

    bp_state_t st_d, st_q;
    logic      hit;

    always_comb begin
        hit     = (bus_addr == REG_ADDR);
        set_req = (hit && bus_wen) ? bus_wdata[FLAG_LSB +: NUM_PAL] : '0;
        st_d    = st_q;
        st_d.rdata = '0;
        if (hit && bus_ren) begin
            st_d.rdata[FLAG_LSB +: NUM_PAL] = flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~FLAG_MASK) == '0); // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ren && hit) |=> (bus_rdata == '0)); // R2
    AST_MISS_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (set_req == '0)); // R5
endmodule

// File: rtl/palette_bank_switch.sv
module palette_bank_switch
    import pbs_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0,
    parameter int unsigned NUM_PAL  = 4,
    parameter int unsigned FLAG_LSB = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wen,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_ren,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               disp_rst,
    input  logic               upd_pulse,
    output logic [NUM_PAL-1:0] bank_sel
);
    logic               evt;
    logic [NUM_PAL-1:0] flags;
    logic [NUM_PAL-1:0] set_req;

    pbs_update_detect u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .disp_rst  (disp_rst),
        .upd_pulse (upd_pulse),
        .evt       (evt)
    );

    pbs_bus_port #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR),
        .NUM_PAL  (NUM_PAL),
        .FLAG_LSB (FLAG_LSB)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_ren   (bus_ren),
        .bus_rdata (bus_rdata),
        .flags     (flags),
        .set_req   (set_req)
    );

    pbs_flag_bank #(
        .NUM_PAL (NUM_PAL)
    ) u_fb (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (set_req),
        .evt      (evt),
        .flags    (flags),
        .bank_sel (bank_sel)
    );
endmodule

// File: tb/tb_palette_bank_switch.sv
module tb_palette_bank_switch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ren = 1'b0;
    logic [31:0] bus_rdata;
    logic        disp_rst = 1'b0;
    logic        upd_pulse = 1'b0;
    logic [3:0]  bank_sel;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural reference model state
    int m_flag [4];
    int m_bank [4];
    int m_prev;
    longint unsigned m_rdata;
    bit model_on = 0;

    palette_bank_switch dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
        .disp_rst(disp_rst), .upd_pulse(upd_pulse), .bank_sel(bank_sel)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model_bank();
        logic [3:0] b;
        for (int i = 0; i < 4; i++) b[i] = (m_bank[i] != 0);
        return b;
    endfunction

    always @(posedge clk) begin
        if (model_on) begin
            bit ev;
            ev = (m_prev == 1 && disp_rst == 1'b0) || upd_pulse;
            m_rdata = 0;
            if (bus_ren && bus_addr == 8'h00)
                for (int i = 0; i < 4; i++) if (m_flag[i] != 0) m_rdata += (64'd1 << (16 + i));
            for (int i = 0; i < 4; i++) begin
                if (ev) begin
                    if (m_flag[i] != 0) m_bank[i] = 1 - m_bank[i];
                    m_flag[i] = 0;
                end else if (bus_wen && bus_addr == 8'h00 && bus_wdata[16+i]) begin
                    m_flag[i] = 1;
                end
            end
            m_prev = disp_rst ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            chk("R8 bank_sel vs model", {28'b0, bank_sel}, {28'b0, model_bank()});
            chk("R2 rdata vs model", bus_rdata, m_rdata[31:0]);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0; bus_addr = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_ren = 1'b1;
        @(negedge clk);
        #1 d = bus_rdata;
        bus_ren = 1'b0; bus_addr = '0;
    endtask

    task automatic pulse();
        @(negedge clk);
        upd_pulse = 1'b1;
        @(negedge clk);
        upd_pulse = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin m_flag[i] = 0; m_bank[i] = 0; end
        m_prev = 0; m_rdata = 0;
        repeat (3) @(negedge clk);
        chk("R1 bank_sel in reset", {28'b0, bank_sel}, 32'h0);
        rst_n = 1'b1;
        model_on = 1;
        @(negedge clk);
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        rd(8'h00, r); chk("R1 flags after reset", r, 32'h0);

        // R4/R3: set palettes 1 and 3, plus reserved bits
        wr(8'h00, 32'hFFF5_FFFF & ~32'h000A_0000);
        rd(8'h00, r); chk("R4 set flags 1,3 / R3 reserved read 0", r, 32'h0005_0000);
        wr(8'h00, 32'h0000_0000);
        rd(8'h00, r); chk("R4 write 0 ignored", r, 32'h0005_0000);
        chk("R3 no toggle from writes", {28'b0, bank_sel}, 32'h0);

        // R5: other address
        wr(8'h04, 32'h000F_0000);
        rd(8'h00, r); chk("R5 other address ignored", r, 32'h0005_0000);
        rd(8'h04, r); chk("R2 read other address is 0", r, 32'h0);

        // R7/R8/R9: update pulse
        pulse();
        chk("R8 toggle flagged palettes", {28'b0, bank_sel}, 32'h5);
        rd(8'h00, r); chk("R9 flags cleared", r, 32'h0);
        pulse();
        chk("R8 no toggle with clear flags", {28'b0, bank_sel}, 32'h5);

        // R6: rising edge no event, falling edge event
        wr(8'h00, 32'h000A_0000);
        @(negedge clk); disp_rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 rising/level no event", {28'b0, bank_sel}, 32'h5);
        rd(8'h00, r); chk("R6 flags kept on rise", r, 32'h000A_0000);
        @(negedge clk); disp_rst = 1'b0;
        @(negedge clk);
        chk("R6 falling edge toggles", {28'b0, bank_sel}, 32'hF);
        rd(8'h00, r); chk("R9 cleared after falling edge", r, 32'h0);

        // R10: write coinciding with event
        wr(8'h00, 32'h0001_0000);
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 32'h0002_0000; bus_wen = 1'b1; upd_pulse = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0; upd_pulse = 1'b0;
        chk("R10 only earlier flag toggles", {28'b0, bank_sel}, 32'hE);
        rd(8'h00, r); chk("R10 clear wins over set", r, 32'h0);

        // all four then event
        wr(8'h00, 32'h000F_0000);
        rd(8'h00, r); chk("R2 all flags read at 19:16", r, 32'h000F_0000);
        pulse();
        chk("R8 all toggle", {28'b0, bank_sel}, 32'h1);
        repeat (4) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule